// File: doc/BRIEF.md
# Integer multiply/divide unit with a HI/LO accumulator

This block is the multiply and divide engine that sits beside the integer datapath of a small RISC core. It holds a double-width result in a pair of registers, HI (upper word) and LO (lower word). Plain multiply and divide write their results only into this pair. Multiply-add and multiply-subtract use the pair as a 64-bit accumulator. Two move operations copy HI or LO out to the register file.

A separate three-operand multiply returns the low word of the product straight on the result port and leaves the pair untouched. The core pulses `start` with an operation code, two operands and a signed/unsigned select. It must hold off further operations while `busy` is high and take its value from `result` when `done` pulses.

The multiplier is shift-and-add by default, or a single wide product when `MUL_ITERATIVE` is 0. The divider is a restoring divider that resolves one quotient bit per cycle.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy`, `done` and `result` are 0, and HI and LO both read back as 0.
- R2: Op code 0 (multiply) writes the full 2*XLEN-bit product of `a` and `b` into {HI,LO}. When `is_signed` is 1 the operands are taken as two's complement, and when it is 0 as unsigned.
- R3: Op code 1 (multiply-add) adds the product to {HI,LO}. The sum wraps modulo 2^(2*XLEN).
- R4: Op code 2 (multiply-subtract) subtracts the product from {HI,LO}. The difference wraps modulo 2^(2*XLEN).
- R5: Op code 3 (divide) writes the quotient a/b into LO and the remainder into HI. In signed mode the quotient is truncated toward zero and the remainder carries the sign of the dividend.
- R6: A divide with `b` equal to 0 sets LO to all ones and HI to the dividend `a`, and gives no other indication.
- R7: Op code 4 (low multiply) puts the low XLEN bits of the product on `result` and leaves HI and LO unchanged.
- R8: Op code 5 puts HI on `result`, and op code 6 puts LO on `result`. Each completes one cycle after it is accepted.
- R9: A start with `busy` low and a valid op code is accepted. `busy` rises on the next cycle and stays high for the operation's latency: 1 cycle for moves, XLEN+1 cycles for divide, and XLEN+1 cycles for multiplies (2 cycles when MUL_ITERATIVE is 0). `done` then pulses for exactly one cycle as `busy` falls.
- R10: A start while `busy` is high is ignored. It does not change the operation in flight, its result or its latency.
- R11: A start with op code 7 is ignored. `busy` stays low, and `result`, HI and LO are unchanged.
- R12: `result` changes only in a cycle where `done` is high. After an operation that targets HI/LO it keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe, one cycle |
| op | input | 3 | Operation code (0..6 valid, 7 ignored) |
| is_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| a | input | XLEN | First operand / dividend |
| b | input | XLEN | Second operand / divisor |
| result | output | XLEN | Value for the register file |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Multiplies are tried with all-ones unsigned operands, which yields the largest carry chain into HI. They are also tried with mixed-sign signed operands, which tells sign handling apart from zero extension. Accumulation is run past both ends of the 64-bit range to show that it wraps rather than saturates. Divides cover every sign combination of dividend and divisor, the most-negative value divided by minus one, and a zero divisor, which separates truncation and remainder-sign rules from an unsigned-only divider. Starts issued mid-operation and starts with the unused op code show whether stray strobes disturb the state. A seeded random stream of all operations is compared against the bench's model every clock.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
   typedef enum logic [2:0] {
      MD_MULT  = 3'd0,
      MD_MADD  = 3'd1,
      MD_MSUB  = 3'd2,
      MD_DIV   = 3'd3,
      MD_MULLO = 3'd4,
      MD_MFHI  = 3'd5,
      MD_MFLO  = 3'd6,
      MD_NONE  = 3'd7
   } md_op_e;

   function automatic logic is_mul_op(md_op_e o);
      return (o == MD_MULT) || (o == MD_MADD) || (o == MD_MSUB) || (o == MD_MULLO);
   endfunction
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
   parameter int XLEN      = 32,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   input  logic              sgn,
   output logic [2*XLEN-1:0] prod
);
   localparam int W2 = 2 * XLEN;

   logic            neg_in;
   logic [XLEN-1:0] mag_a, mag_b;
   logic            neg_q;
   logic [W2-1:0]   mag_prod;

   // magnitudes: signed operands are folded to unsigned, sign restored at the end
   assign neg_in = sgn & (a[XLEN-1] ^ b[XLEN-1]);
   assign mag_a  = (sgn && a[XLEN-1]) ? (~a + 1'b1) : a;
   assign mag_b  = (sgn && b[XLEN-1]) ? (~b + 1'b1) : b;

   always_ff @(posedge clk) begin
      if (!rst_n)    neg_q <= 1'b0;
      else if (load) neg_q <= neg_in;
   end

   generate
      if (ITERATIVE) begin : g_iter
         logic [W2-1:0]   acc_q, mcand_q;
         logic [XLEN-1:0] mplier_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q    <= '0;
               mcand_q  <= '0;
               mplier_q <= '0;
            end else if (load) begin
               acc_q    <= '0;
               mcand_q  <= {{XLEN{1'b0}}, mag_a};
               mplier_q <= mag_b;
            end else if (step) begin
               if (mplier_q[0]) acc_q <= acc_q + mcand_q;
               mcand_q  <= mcand_q << 1;
               mplier_q <= mplier_q >> 1;
            end
         end
         assign mag_prod = acc_q;
      end else begin : g_flat
         logic [W2-1:0] full_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    full_q <= '0;
            else if (load) full_q <= {{XLEN{1'b0}}, mag_a} * {{XLEN{1'b0}}, mag_b};
         end
         assign mag_prod = full_q;
      end
   endgenerate

   assign prod = neg_q ? (~mag_prod + 1'b1) : mag_prod;
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            sgn,
   output logic [XLEN-1:0] quo,
   output logic [XLEN-1:0] rem
);
   logic [XLEN-1:0] mag_a, mag_b;
   logic [XLEN-1:0] rem_q, quo_q, den_q, raw_a_q;
   logic            negq_q, negr_q, zero_q;
   logic [XLEN:0]   shifted, diff;

   assign mag_a = (sgn && a[XLEN-1]) ? (~a + 1'b1) : a;
   assign mag_b = (sgn && b[XLEN-1]) ? (~b + 1'b1) : b;

   // one restoring step: bring in next dividend bit, try subtracting divisor
   assign shifted = {rem_q, quo_q[XLEN-1]};
   assign diff    = shifted - {1'b0, den_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         quo_q   <= '0;
         den_q   <= '0;
         raw_a_q <= '0;
         negq_q  <= 1'b0;
         negr_q  <= 1'b0;
         zero_q  <= 1'b0;
      end else if (load) begin
         rem_q   <= '0;
         quo_q   <= mag_a;
         den_q   <= mag_b;
         raw_a_q <= a;
         negq_q  <= sgn & (a[XLEN-1] ^ b[XLEN-1]);
         negr_q  <= sgn & a[XLEN-1];
         zero_q  <= (b == '0);
      end else if (step) begin
         if (!diff[XLEN]) begin
            rem_q <= diff[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], 1'b1};
         end else begin
            rem_q <= shifted[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], 1'b0};
         end
      end
   end

   always_comb begin
      if (zero_q) begin
         quo = '1;
         rem = raw_a_q;
      end else begin
         quo = negq_q ? (~quo_q + 1'b1) : quo_q;
         rem = negr_q ? (~rem_q + 1'b1) : rem_q;
      end
   end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
   import muldiv_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter bit MUL_ITERATIVE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [2:0]      op,
   input  logic            is_signed,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] result,
   output logic            busy,
   output logic            done
);
   localparam int W2      = 2 * XLEN;
   localparam int MUL_LAT = MUL_ITERATIVE ? XLEN + 1 : 2;
   localparam int DIV_LAT = XLEN + 1;
   localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
   localparam int CW      = $clog2(MAX_LAT + 1);

   generate
      if (XLEN < 4 || (XLEN % 2) != 0) begin : g_bad_xlen
         $error("muldiv_hilo: XLEN must be even and at least 4");
      end
   endgenerate

   md_op_e          op_in, op_q;
   logic            busy_q, done_q;
   logic [CW-1:0]   cnt_q, lat_in;
   logic [XLEN-1:0] hi_q, lo_q, result_q;
   logic            accept, finish, step;
   logic [W2-1:0]   prod, acc_sum, acc_diff;
   logic [XLEN-1:0] quo, rem;

   assign op_in  = md_op_e'(op);
   assign accept = start && !busy_q && (op_in != MD_NONE);
   assign finish = busy_q && (cnt_q == CW'(1));
   assign step   = busy_q && (cnt_q != CW'(1));

   always_comb begin
      if (op_in == MD_DIV)      lat_in = CW'(DIV_LAT);
      else if (is_mul_op(op_in)) lat_in = CW'(MUL_LAT);
      else                       lat_in = CW'(1);
   end

   muldiv_mul #(.XLEN(XLEN), .ITERATIVE(MUL_ITERATIVE)) u_mul (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept && is_mul_op(op_in)),
      .step (step),
      .a    (a),
      .b    (b),
      .sgn  (is_signed),
      .prod (prod)
   );

   muldiv_div #(.XLEN(XLEN)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .load (accept && (op_in == MD_DIV)),
      .step (step),
      .a    (a),
      .b    (b),
      .sgn  (is_signed),
      .quo  (quo),
      .rem  (rem)
   );

   assign acc_sum  = {hi_q, lo_q} + prod;
   assign acc_diff = {hi_q, lo_q} - prod;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         cnt_q    <= '0;
         op_q     <= MD_NONE;
         hi_q     <= '0;
         lo_q     <= '0;
         result_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= lat_in;
            op_q   <= op_in;
         end else if (finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            cnt_q  <= '0;
            unique case (op_q)
               MD_MULT:  {hi_q, lo_q} <= prod;
               MD_MADD:  {hi_q, lo_q} <= acc_sum;
               MD_MSUB:  {hi_q, lo_q} <= acc_diff;
               MD_DIV:   begin
                  hi_q <= rem;
                  lo_q <= quo;
               end
               MD_MULLO: result_q <= prod[XLEN-1:0];
               MD_MFHI:  result_q <= hi_q;
               MD_MFLO:  result_q <= lo_q;
               default:  ;
            endcase
         end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign result = result_q;
   assign busy   = busy_q;
   assign done   = done_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
   parameter int XLEN          = 32,
   parameter bit MUL_ITERATIVE = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [2:0]      op,
   input logic [XLEN-1:0] result,
   input logic            busy,
   input logic            done
);
   localparam int MAX_LAT = XLEN + 1;
   localparam int RW      = $clog2(MAX_LAT + 2);

   logic [RW-1:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op != 3'd7) |=> busy);
   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);
   assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op == 3'd7) |=> (!busy && $stable(result)));
   assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);
   assert_busy_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < RW'(MAX_LAT)));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.XLEN(XLEN), .MUL_ITERATIVE(MUL_ITERATIVE)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .op    (op),
   .result(result),
   .busy  (busy),
   .done  (done)
);

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd7;
   logic        is_signed = 1'b0;
   logic [31:0] a = '0, b = '0;
   logic [31:0] result;
   logic        busy, done;

   int checks = 0, fails = 0, cyc = 0;

   always #10 clk = ~clk;

   muldiv_hilo u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_signed(is_signed),
      .a(a), .b(b), .result(result), .busy(busy), .done(done)
   );

   // behavioural reference model
   logic        m_busy = 0, m_done = 0;
   int          m_cnt = 0;
   logic [31:0] m_hi = 0, m_lo = 0, m_res = 0;
   logic [2:0]  m_op = 0;
   logic        m_sg = 0;
   logic [31:0] m_a = 0, m_b = 0;

   function automatic int lat(logic [2:0] o);
      if (o == 3'd5 || o == 3'd6) return 1;
      return 33;
   endfunction

   function automatic logic [63:0] ext(logic [31:0] v, logic sg);
      return sg ? {{32{v[31]}}, v} : {32'b0, v};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_hi = 0; m_lo = 0; m_res = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
               logic [63:0] p, hl;
               longint sa, sb, q, r;
               m_busy = 0; m_done = 1;
               p  = ext(m_a, m_sg) * ext(m_b, m_sg);
               hl = {m_hi, m_lo};
               case (m_op)
                  3'd0: {m_hi, m_lo} = p;
                  3'd1: {m_hi, m_lo} = hl + p;
                  3'd2: {m_hi, m_lo} = hl - p;
                  3'd3: begin
                     if (m_b == 0) begin
                        m_lo = 32'hFFFF_FFFF; m_hi = m_a;
                     end else begin
                        sa = longint'(ext(m_a, m_sg));
                        sb = longint'(ext(m_b, m_sg));
                        q = sa / sb; r = sa % sb;
                        m_lo = q[31:0]; m_hi = r[31:0];
                     end
                  end
                  3'd4: m_res = p[31:0];
                  3'd5: m_res = m_hi;
                  3'd6: m_res = m_lo;
                  default: ;
               endcase
            end
         end else if (start && op != 3'd7) begin
            m_busy = 1; m_cnt = lat(op); m_op = op; m_sg = is_signed; m_a = a; m_b = b;
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // every-clock comparison against the model (R9 timing, R12 result)
   always @(negedge clk) begin
      if (rst_n) begin
         check("R9 busy", {31'b0, busy}, {31'b0, m_busy});
         check("R9 done", {31'b0, done}, {31'b0, m_done});
         check("R12 result", result, m_res);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++; checks++;
         $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic issue(logic [2:0] o, logic sg, logic [31:0] x, logic [31:0] y);
      @(negedge clk);
      start = 1; op = o; is_signed = sg; a = x; b = y;
      @(negedge clk);
      start = 0;
      while (m_busy) @(negedge clk);
   endtask

   task automatic read_hilo(string tag, logic [31:0] ehi, logic [31:0] elo);
      issue(3'd5, 0, 0, 0);
      check({tag, " HI"}, result, ehi);
      issue(3'd6, 0, 0, 0);
      check({tag, " LO"}, result, elo);
   endtask

   initial begin
      logic [31:0] held;
      @(negedge clk);
      check("R1 busy", {31'b0, busy}, 0);
      check("R1 done", {31'b0, done}, 0);
      check("R1 result", result, 0);
      repeat (2) @(negedge clk);
      rst_n = 1;
      read_hilo("R1", 0, 0);

      issue(3'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      read_hilo("R2 unsigned", 32'hFFFF_FFFE, 32'h0000_0001);
      issue(3'd0, 1, 32'hFFFF_FFFD, 32'd7);
      read_hilo("R2 signed", 32'hFFFF_FFFF, 32'hFFFF_FFEB);

      issue(3'd1, 1, 32'd5, 32'd4);
      read_hilo("R3 madd", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      issue(3'd1, 0, 32'd1, 32'd2);
      read_hilo("R3 wrap", 32'h0, 32'h1);

      issue(3'd2, 0, 32'd2, 32'd1);
      read_hilo("R4 wrap", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      issue(3'd2, 1, 32'hFFFF_FFFF, 32'd3);
      read_hilo("R4 msub", 32'h0, 32'h2);

      issue(3'd3, 1, 32'hFFFF_FFF9, 32'd2);
      read_hilo("R5 -7/2", 32'hFFFF_FFFF, 32'hFFFF_FFFD);
      issue(3'd3, 1, 32'd7, 32'hFFFF_FFFE);
      read_hilo("R5 7/-2", 32'h1, 32'hFFFF_FFFD);
      issue(3'd3, 0, 32'hFFFF_FFF9, 32'd2);
      read_hilo("R5 unsigned", 32'h1, 32'h7FFF_FFFC);
      issue(3'd3, 1, 32'h8000_0000, 32'hFFFF_FFFF);
      read_hilo("R5 minneg", 32'h0, 32'h8000_0000);

      issue(3'd3, 1, 32'h0000_1234, 32'd0);
      read_hilo("R6 div0", 32'h0000_1234, 32'hFFFF_FFFF);

      issue(3'd0, 0, 32'h0001_0000, 32'h0003_0005);
      issue(3'd4, 1, 32'hFFFF_FFFE, 32'd9);
      check("R7 low word", result, 32'hFFFF_FFEE);
      read_hilo("R7 untouched", 32'h3, 32'h0005_0000);

      issue(3'd5, 0, 0, 0);
      check("R8 move hi", result, 32'h3);

      // R10: second strobe mid-flight
      held = result;
      @(negedge clk);
      start = 1; op = 3'd0; is_signed = 0; a = 32'd6; b = 32'd7;
      @(negedge clk);
      op = 3'd6;
      repeat (3) @(negedge clk);
      start = 0;
      while (m_busy) @(negedge clk);
      check("R10 result kept", result, held);
      read_hilo("R10 first op only", 32'h0, 32'd42);

      // R11: unused op code
      held = result;
      @(negedge clk);
      start = 1; op = 3'd7; a = 32'd3; b = 32'd3;
      @(negedge clk);
      start = 0;
      check("R11 busy", {31'b0, busy}, 0);
      @(negedge clk);
      check("R11 result", result, held);
      read_hilo("R11 hilo", 32'h0, 32'd42);

      for (int i = 0; i < 40; i++) begin
         logic [2:0] ro;
         ro = 3'($urandom_range(0, 6));
         issue(ro, 1'($urandom_range(0, 1)), $urandom, (i % 7 == 0) ? 32'd0 : $urandom);
      end
      read_hilo("R3 random", m_hi, m_lo);

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule